// File: doc/BRIEF.md
# FIFO Threshold Offset Register Bank

This block holds the two programmable thresholds that a FIFO's almost-empty and almost-full flag logic compares against. Software or a neighbouring controller loads them byte by byte over the FIFO's own write data bus. A load strobe is shared with the write path. A two-bit write index steps through four storage slots and wraps after the last one. The index keeps its position when a load burst is interrupted, so a later burst carries on with the next slot.

The same slots can be read back over the read data bus. A separate two-bit index in the read clock domain walks them in the same cyclic order. Each threshold is log2(DEPTH) bits wide: an 8-bit low byte plus a high fragment of log2(DEPTH)-8 bits. The block only responds when programmable-threshold mode was chosen by holding the load strobe low during reset. In the other mode every load and readback request is ignored, and both thresholds stay at their reset value of 7.

Top module: `othr_bank`

## Requirements
- R1: While `rst` is high on a clock edge, both thresholds become 7 and `rd_data` becomes 0. Both slot indices return to slot 0, and the slots take their defaults: low bytes 07h, high fragments 0.
- R2: A high-fragment slot (slot 1 or slot 3) keeps only `wr_data[HI_W-1:0]`, where HI_W = log2(DEPTH)-8. On readback, all bits above HI_W-1 read as zero.
- R3: Programmable mode is on only if `load_n` is low during reset. If `load_n` was high during reset, load and readback requests change neither the thresholds nor `rd_data`.
- R4: A `wr_clk` edge with `load_n` low and `wen1_n` low writes one slot and then advances the write index. Slot 0 is the empty low byte and takes `wr_data[7:0]`, with bit 8 ignored. Slot 1 is the empty high fragment. Slot 2 is the full low byte. Slot 3 is the full high fragment.
- R5: The load edge that follows a write to slot 3 writes slot 0.
- R6: A `wr_clk` edge with `load_n` high or `wen1_n` high writes no slot and leaves the write index where it is, so the next load continues with the next slot in sequence.
- R7: A `rd_clk` edge with `load_n`, `ren1_n` and `ren2_n` all low puts the slot at the read index on `rd_data`, zero-extended, and advances the read index. If either read enable is high, `rd_data` holds its value.
- R8: `empty_thr` = {slot 1, slot 0} and `full_thr` = {slot 3, slot 2}. Both are registered on `wr_clk` and appear one edge after the slot write.
- R9: The read index wraps from slot 3 to slot 0 on its own, independently of the write index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; slot writes and threshold outputs |
| rd_clk | input | 1 | Read-side clock; readback path |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| load_n | input | 1 | Active-low load strobe; its level during reset selects the mode |
| wen1_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | Active-low read enable, first |
| ren2_n | input | 1 | Active-low read enable, second |
| wr_data | input | DATA_W (9) | Write data bus |
| rd_data | output | DATA_W (9) | Readback data |
| empty_thr | output | log2(DEPTH) | Almost-empty threshold |
| full_thr | output | log2(DEPTH) | Almost-full threshold |

## Verification
The bench builds the block with DEPTH = 2048, which gives 3-bit high fragments. Data patterns with bits set above bit 2 therefore show whether the high-fragment slots truncate correctly. Writing 9-bit values with bit 8 set shows that the low-byte slots discard that bit. Both clocks run at the same rate with a fixed phase offset. This lets a single load strobe be shared between write and read requests without either side acting on the other's cycle, and it exercises wrap-around and an interrupted burst on each index separately.

// File: rtl/othr_pkg.sv
package othr_pkg;
  localparam int SLOT_N = 4;
  localparam int SLOT_W = 8;
  localparam int IDX_W  = $clog2(SLOT_N);

  typedef enum logic [IDX_W-1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  // Even slots are low bytes (default 7), odd slots are high fragments (default 0)
  function automatic logic [SLOT_W-1:0] slot_default(input int i);
    return (i % 2 == 0) ? 8'h07 : 8'h00;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_mask(input int i, input int hi_w);
    return (i % 2 == 0) ? 8'hFF : 8'((1 << hi_w) - 1);
  endfunction
endpackage

// File: rtl/othr_wr_bank.sv
module othr_wr_bank
  import othr_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int HI_W  = AW - 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_n,
  input  logic                     wen1_n,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [SLOT_N*SLOT_W-1:0] slots_flat,
  output logic [AW-1:0]            empty_thr,
  output logic [AW-1:0]            full_thr
);
  logic             prog_mode;
  logic [IDX_W-1:0] widx;
  logic             wr_hit;
  logic [SLOT_W-1:0] slot [SLOT_N];
  logic             unused_top;

  assign unused_top = ^wr_data[DATA_W-1:SLOT_W];
  assign wr_hit = prog_mode && !load_n && !wen1_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_mode <= !load_n;
      widx      <= SLOT_E_LO;
    end else if (wr_hit) begin
      widx <= widx + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    localparam logic [SLOT_W-1:0] RST_V = slot_default(g);
    localparam logic [SLOT_W-1:0] MASK  = slot_mask(g, HI_W);
    always_ff @(posedge clk) begin
      if (rst)
        slot[g] <= RST_V;
      else if (wr_hit && widx == IDX_W'(g))
        slot[g] <= wr_data[SLOT_W-1:0] & MASK;
    end
    assign slots_flat[g*SLOT_W +: SLOT_W] = slot[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_thr <= AW'(7);
      full_thr  <= AW'(7);
    end else begin
      empty_thr <= {slot[SLOT_E_HI][HI_W-1:0], slot[SLOT_E_LO]};
      full_thr  <= {slot[SLOT_F_HI][HI_W-1:0], slot[SLOT_F_LO]};
    end
  end

  // R1: first cycle after reset shows default thresholds
  p_thr_default_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty_thr == AW'(7) && full_thr == AW'(7)));

  // R4 / R5: an accepted load steps the index by one, wrapping
  p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> widx == IDX_W'($past(widx) + 1'b1));

  // R6: no accepted load keeps the index in place
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(widx));

  // R3: outside programmable mode the slots never change
  p_mode_lock_r3: assert property (@(posedge clk) disable iff (rst)
    !prog_mode |=> $stable(slots_flat));
endmodule

// File: rtl/othr_rd_port.sv
module othr_rd_port
  import othr_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int HI_W  = AW - 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_n,
  input  logic                     ren1_n,
  input  logic                     ren2_n,
  input  logic [SLOT_N*SLOT_W-1:0] slots_flat,
  output logic [DATA_W-1:0]        rd_data
);
  logic             prog_mode;
  logic [IDX_W-1:0] ridx;
  logic             rd_hit;
  logic [SLOT_W-1:0] sel;

  assign rd_hit = prog_mode && !load_n && !ren1_n && !ren2_n;
  assign sel    = slots_flat[ridx*SLOT_W +: SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_mode <= !load_n;
      ridx      <= SLOT_E_LO;
      rd_data   <= '0;
    end else if (rd_hit) begin
      ridx    <= ridx + 1'b1;
      rd_data <= {{(DATA_W-SLOT_W){1'b0}}, sel};
    end
  end

  // R7: without a read request the output holds
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(rd_data));

  // R2: a high-fragment readback carries zeros above the fragment
  p_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && ridx[0]) |=> rd_data[DATA_W-1:HI_W] == '0);

  // R9: read index steps by one per accepted read
  p_ridx_step_r9: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> ridx == IDX_W'($past(ridx) + 1'b1));
endmodule

// File: rtl/othr_bank.sv
module othr_bank
  import othr_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              wen1_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     empty_thr,
  output logic [AW-1:0]     full_thr
);
  logic [SLOT_N*SLOT_W-1:0] slots_flat;

  othr_wr_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_wr (
    .clk        (wr_clk),
    .rst        (rst),
    .load_n     (load_n),
    .wen1_n     (wen1_n),
    .wr_data    (wr_data),
    .slots_flat (slots_flat),
    .empty_thr  (empty_thr),
    .full_thr   (full_thr)
  );

  othr_rd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rd (
    .clk        (rd_clk),
    .rst        (rst),
    .load_n     (load_n),
    .ren1_n     (ren1_n),
    .ren2_n     (ren2_n),
    .slots_flat (slots_flat),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/othr_bank_test.sv
`timescale 1ns/1ps
module othr_bank_test;
  localparam int DEPTH = 2048;
  localparam int DW    = 9;
  localparam int AW    = $clog2(DEPTH);

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst = 1'b1, load_n = 1'b1, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] empty_thr, full_thr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 wr_clk = ~wr_clk;
  initial begin #2; forever #5 rd_clk = ~rd_clk; end

  othr_bank #(.DEPTH(DEPTH), .DATA_W(DW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .load_n(load_n),
    .wen1_n(wen1_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .wr_data(wr_data),
    .rd_data(rd_data), .empty_thr(empty_thr), .full_thr(full_thr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit prog);
    @(negedge wr_clk);
    rst = 1'b1; load_n = prog ? 1'b0 : 1'b1;
    repeat (3) @(negedge wr_clk);
    rst = 1'b0; load_n = 1'b1;
    @(negedge wr_clk);
  endtask

  task automatic load_slot(input logic [DW-1:0] d);
    @(negedge wr_clk);
    load_n = 1'b0; wen1_n = 1'b0; wr_data = d;
    @(negedge wr_clk);
    load_n = 1'b1; wen1_n = 1'b1;
    @(negedge wr_clk);
  endtask

  task automatic read_slot(input string req, input int exp);
    @(negedge rd_clk);
    load_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rd_clk);
    load_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    chk("R1 empty_thr", empty_thr, 7);
    chk("R1 full_thr", full_thr, 7);
    chk("R1 rd_data", rd_data, 0);
    read_slot("R1 slot0 default", 'h07);
    read_slot("R1 slot1 default", 'h00);
    read_slot("R1 slot2 default", 'h07);
    read_slot("R1 slot3 default", 'h00);
  endtask

  task automatic t_full_load();
    load_slot(9'h1A5);
    chk("R8 empty after slot0", empty_thr, 'h0A5);
    load_slot(9'h0FF);
    load_slot(9'h033);
    load_slot(9'h1F2);
    chk("R4 R2 empty_thr", empty_thr, 'h7A5);
    chk("R4 R2 full_thr", full_thr, 'h233);
    read_slot("R9 R7 slot0 readback", 'h0A5);
    read_slot("R2 slot1 readback", 'h007);
    read_slot("R7 slot2 readback", 'h033);
    read_slot("R2 slot3 readback", 'h002);
  endtask

  task automatic t_wrap_resume();
    load_slot(9'h011);
    chk("R5 wrap to slot0", empty_thr, 'h711);
    @(negedge wr_clk);
    load_n = 1'b1; wen1_n = 1'b0; wr_data = 9'h055;
    @(negedge wr_clk);
    load_n = 1'b0; wen1_n = 1'b1;
    @(negedge wr_clk);
    load_n = 1'b1;
    @(negedge wr_clk);
    chk("R6 no write empty", empty_thr, 'h711);
    chk("R6 no write full", full_thr, 'h233);
    load_slot(9'h004);
    chk("R6 resume slot1", empty_thr, 'h411);
    chk("R6 full untouched", full_thr, 'h233);
  endtask

  task automatic t_read_hold();
    read_slot("R9 read wraps slot0", 'h011);
    @(negedge rd_clk);
    load_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge rd_clk);
    ren1_n = 1'b1; ren2_n = 1'b0;
    @(negedge rd_clk);
    load_n = 1'b1; ren2_n = 1'b1;
    chk("R7 hold one enable high", rd_data, 'h011);
    read_slot("R7 next slot1", 'h004);
  endtask

  task automatic t_plain_mode();
    do_reset(1'b0);
    chk("R1 reset clears custom empty", empty_thr, 7);
    load_slot(9'h022);
    load_slot(9'h001);
    chk("R3 empty ignored", empty_thr, 7);
    chk("R3 full ignored", full_thr, 7);
    read_slot("R3 readback ignored", 0);
  endtask

  initial begin
    t_reset_state();
    t_full_load();
    t_wrap_resume();
    t_read_hold();
    t_plain_mode();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge wr_clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule